// File: doc/BRIEF.md
# Song Sequencer Control Unit

The block plays one stored song at a time. Songs sit in a byte-addressed memory that answers in the same cycle, one 32-bit word per note, each song at a fixed stride of 512 bytes. While the block waits, it keeps its address register pointed at the start of the selected song. A start pulse begins playback. The sequencer then reads one word, hands the decoded note to a note-player sub-block with a single-cycle load strobe, and waits for that sub-block to report done before it reads the next word. A word with every bit set ends the song and returns the sequencer to waiting.

The memory port has no back-pressure: a request is valid only in the fetch cycle, and the data must be valid in that same cycle. The note-player side uses load as its valid strobe and done as its ready: no second load is issued until done has been seen. The note length sent with every note comes from a configuration input that is held constant after reset.

Top module: `song_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `idle`, `mem_req_val` and `note_load` are low. `idle` rises in the second cycle after release.
- R2: `idle` is high only while the sequencer waits for a start. A high `start` while waiting makes `idle` low in the next cycle, and that cycle is a fetch cycle.
- R3: The first fetch of a song uses the byte address `song_sel * 512`, where `song_sel` is the value sampled in the cycle when `start` was accepted.
- R4: `mem_req_val` is high only in fetch cycles. It is low while waiting, while a note plays, and during reset.
- R5: When a fetched word is not all ones, `note_load` is high for exactly that fetch cycle. In that cycle `note_code` equals bits [2:0] of the word (0 rest, 1 to 7 the notes G, A, B, C, D, E, F) and `note_len` equals `note_len_cfg`.
- R6: Each issued note advances the fetch address by 4 bytes, so fetch k of a song reads `song_sel*512 + 4k`.
- R7: A fetched word of 32'hFFFF_FFFF issues no load, and `idle` is high in the next cycle.
- R8: After a load, no fetch takes place until `note_done` is seen high. The fetch of the next word happens in the cycle after `note_done` is first high. `note_done` has no effect while waiting.
- R9: `start` and changes of `song_sel` have no effect while a song plays.
- R10: A word of 0 is a rest: it issues a load with `note_code` 0 and the song continues.
- R11: Any word other than all ones is played as a note from its bits [2:0]. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| song_sel | input | 5 | Song number, sampled while waiting |
| start | input | 1 | Start request, accepted only while waiting |
| note_len_cfg | input | 8 | Note length passed to the note player |
| mem_rdata | input | 32 | Memory read word, valid in the request cycle |
| note_done | input | 1 | Note player has finished the current note |
| idle | output | 1 | Waiting for a start |
| mem_req_val | output | 1 | Memory read request |
| mem_req_addr | output | 16 | Byte address of the request |
| note_load | output | 1 | One-cycle strobe that loads a note |
| note_code | output | 3 | Note code that goes with `note_load` |
| note_len | output | 8 | Note length that goes with `note_load` |

## Verification
Assertions check the port rules on every cycle. A load occurs only together with a memory request, and it lasts a single cycle. No request is made while waiting. An accepted start leads to a fetch at the song base address. Every issued note advances the address by four. An end word never loads and always returns to waiting. A playing note is held until done arrives. Only the bench's scenarios can show that whole songs are walked in the right order, and that an empty song and a done of zero length behave as required. They also show that start, song select and done are ignored outside the states where they count, and that upper bits of odd words do not change the note.

// File: rtl/song_seq_pkg.sv
package song_seq_pkg;
  typedef enum logic [1:0] {
    SQ_BOOT  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_FETCH = 2'd2,
    SQ_PLAY  = 2'd3
  } sq_state_t;
endpackage

// File: rtl/song_word_decode.sv
module song_word_decode #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 3
) (
  input  logic [DATA_W-1:0] word,
  output logic              is_end,
  output logic [CODE_W-1:0] code
);
  assign is_end = &word;
  assign code   = word[CODE_W-1:0];
endmodule

// File: rtl/song_addr_reg.sv
module song_addr_reg #(
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 16,
  parameter int SHIFT  = 9,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              step,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] base;
  assign base = ADDR_W'(sel) << SHIFT;

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (init) addr <= base;
    else if (step) addr <= addr + STEP_V;
  end
endmodule

// File: rtl/song_seq_fsm.sv
module song_seq_fsm
  import song_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      word_end,
  input  logic      note_done,
  output sq_state_t state,
  output logic      addr_init,
  output logic      addr_step,
  output logic      req_val,
  output logic      load,
  output logic      idle
);
  sq_state_t nxt;

  always_comb begin
    nxt       = state;
    addr_init = 1'b0;
    addr_step = 1'b0;
    req_val   = 1'b0;
    load      = 1'b0;
    idle      = 1'b0;
    case (state)
      SQ_BOOT: nxt = SQ_WAIT;
      SQ_WAIT: begin
        idle      = 1'b1;
        addr_init = 1'b1;
        if (start) nxt = SQ_FETCH;
      end
      SQ_FETCH: begin
        req_val = 1'b1;
        if (word_end) begin
          nxt = SQ_WAIT;
        end else begin
          load      = 1'b1;
          addr_step = 1'b1;
          nxt       = SQ_PLAY;
        end
      end
      SQ_PLAY: if (note_done) nxt = SQ_FETCH;
      default: nxt = SQ_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_BOOT;
    else     state <= nxt;
  end

  p_hold_until_done_r8: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_PLAY && !note_done) |=> (state == SQ_PLAY));
endmodule

// File: rtl/song_seq_ctrl.sv
module song_seq_ctrl #(
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CODE_W = 3,
  parameter int LEN_W  = 8,
  parameter int SHIFT  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  song_sel,
  input  logic              start,
  input  logic [LEN_W-1:0]  note_len_cfg,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              note_done,
  output logic              idle,
  output logic              mem_req_val,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              note_load,
  output logic [CODE_W-1:0] note_code,
  output logic [LEN_W-1:0]  note_len
);
  import song_seq_pkg::*;

  localparam int STEP = DATA_W / 8;

  sq_state_t         state;
  logic              word_end, addr_init, addr_step;
  logic [ADDR_W-1:0] addr_q;

  song_word_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dec (
    .word(mem_rdata), .is_end(word_end), .code(note_code));

  song_addr_reg #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst), .init(addr_init), .step(addr_step),
    .sel(song_sel), .addr(addr_q));

  song_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .word_end(word_end),
    .note_done(note_done), .state(state), .addr_init(addr_init),
    .addr_step(addr_step), .req_val(mem_req_val), .load(note_load),
    .idle(idle));

  assign mem_req_addr = addr_q;
  assign note_len     = note_len_cfg;

  p_load_with_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    note_load |-> mem_req_val);
  p_load_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    note_load |=> !note_load);
  p_no_req_idle_r4: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mem_req_val);
  p_start_base_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && start) |=>
      (mem_req_val && mem_req_addr == (ADDR_W'($past(song_sel)) << SHIFT)));
  p_step_four_r6: assert property (@(posedge clk) disable iff (rst)
    note_load |=> (addr_q == $past(addr_q) + ADDR_W'(STEP)));
  p_end_no_load_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_val && (&mem_rdata)) |-> !note_load);
  p_end_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_val && (&mem_rdata)) |=> idle);
endmodule

// File: tb/test_song_seq_ctrl.sv
`timescale 1ns/100ps
module test_song_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  song_sel = '0;
  logic        start = 1'b0;
  logic [7:0]  note_len_cfg = 8'd37;
  logic [31:0] mem_rdata;
  logic        note_done = 1'b0;
  logic        idle, mem_req_val, note_load;
  logic [15:0] mem_req_addr;
  logic [2:0]  note_code;
  logic [7:0]  note_len;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  song_seq_ctrl i_song_seq_ctrl (
    .clk(clk), .rst(rst), .song_sel(song_sel), .start(start),
    .note_len_cfg(note_len_cfg), .mem_rdata(mem_rdata), .note_done(note_done),
    .idle(idle), .mem_req_val(mem_req_val), .mem_req_addr(mem_req_addr),
    .note_load(note_load), .note_code(note_code), .note_len(note_len));

  function automatic logic [31:0] song_word(input logic [15:0] a);
    case (a)
      16'h0200: song_word = 32'd3;
      16'h0204: song_word = 32'd0;
      16'h0208: song_word = 32'd7;
      16'h3E00: song_word = 32'h0000_0105;
      16'h3E04: song_word = 32'h0000_0002;
      16'h0400: song_word = 32'hFFFF_FFF9;
      default:  song_word = 32'hFFFF_FFFF;
    endcase
  endfunction

  always_comb mem_rdata = song_word(mem_req_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    check(!idle && !mem_req_val && !note_load, "R1 during reset",
          {idle, mem_req_val, note_load}, 0);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check(!idle && !mem_req_val && !note_load, "R1 first cycle",
          {idle, mem_req_val, note_load}, 0);
    @(negedge clk);
    #0.5;
    check(idle == 1'b1, "R1 idle after reset", idle, 1);
  endtask

  task automatic idle_ignores_done();
    @(negedge clk);
    note_done = 1'b1;
    repeat (2) begin
      @(negedge clk);
      #0.5;
      check(idle && !mem_req_val, "R8 done ignored while idle",
            {idle, mem_req_val}, 2'b10);
    end
    note_done = 1'b0;
  endtask

  task automatic play_song(input logic [4:0] sel, input int hold);
    logic [15:0] a;
    logic [31:0] w;
    a = 16'(sel) << 9;
    @(negedge clk);
    song_sel = sel;
    start = 1'b1;
    #0.5;
    check(idle == 1'b1, "R2 idle before start", idle, 1);
    @(negedge clk);
    start = 1'b0;
    song_sel = ~sel;
    forever begin
      #0.5;
      w = song_word(a);
      check(mem_req_val && !idle, "R4 R2 fetch cycle",
            {mem_req_val, idle}, 2'b10);
      check(mem_req_addr == a, "R3 R6 fetch address", mem_req_addr, a);
      if (&w) begin
        check(!note_load, "R7 end word no load", note_load, 0);
        @(negedge clk);
        #0.5;
        check(idle == 1'b1, "R7 idle after end", idle, 1);
        break;
      end
      check(note_load == 1'b1, "R5 load strobe", note_load, 1);
      check(note_code == w[2:0], "R5 R10 R11 note code", note_code, w[2:0]);
      check(note_len == note_len_cfg, "R5 note length", note_len, note_len_cfg);
      @(negedge clk);
      start = 1'b1;
      for (int k = 0; k < hold; k++) begin
        #0.5;
        check(!mem_req_val && !note_load && !idle, "R8 R9 hold while playing",
              {mem_req_val, note_load, idle}, 0);
        @(negedge clk);
      end
      note_done = 1'b1;
      #0.5;
      check(!mem_req_val && !note_load, "R8 done cycle",
            {mem_req_val, note_load}, 0);
      @(negedge clk);
      note_done = 1'b0;
      start = 1'b0;
      a = a + 16'd4;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    idle_ignores_done();
    play_song(5'd1, 3);
    play_song(5'd31, 0);
    play_song(5'd0, 2);
    play_song(5'd2, 1);
    play_song(5'd1, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule